// File: doc/BRIEF.md
# DRAM Write Command Spacing Checker

This block lives inside a DRAM command scheduler. Each DRAM clock it answers one question: may a WRITE to the requested rank and bank issue now? It watches every command the scheduler issues (ACT, READ, WRITE or no-op), each tagged with a rank and a bank. From these it keeps saturating down-counters at three levels: one per rank-bank for activate-to-write, one per rank for write-to-write, and one for the whole channel for read-to-write.

A single 16-bit read/write spacing register holds the four minimum gaps, all counted in DRAM clocks. A WRITE is reported as allowed only when every counter that covers the requested rank and bank has run out. The answer is combinational from the counters and the request, so the scheduler can use it in the same cycle. A command seen in a given cycle affects the answer from the next cycle on.

Top module: `wr_space_chk`

## Requirements
- R1: The spacing register resets to 0x0000. A write through `cfg_we`/`cfg_wdata` is visible on `cfg_rdata` from the next cycle. Its fields are: bits 15:12 ACT-to-WRITE gap, bits 11:8 same-rank WRITE-to-WRITE gap, bits 7:4 different-rank WRITE-to-WRITE gap, bits 3:0 READ-to-WRITE gap.
- R2: An ACT in cycle t to rank r, bank b with ACT-to-WRITE gap N blocks WRITEs to that same rank-bank only. For k >= 1, `wr_ok` for (r,b) in cycle t+k is 1 exactly when k >= N.
- R3: A WRITE in cycle t to rank r with same-rank gap S blocks WRITEs to rank r. `wr_ok` for rank r in cycle t+k is 1 exactly when k >= S.
- R4: A WRITE in cycle t to rank r with different-rank gap D blocks WRITEs to every other rank. `wr_ok` for those ranks in cycle t+k is 1 exactly when k >= D.
- R5: A READ in cycle t with gap R blocks WRITEs to every rank and bank, whatever the READ's own rank. `wr_ok` in cycle t+k is 1 exactly when k >= R.
- R6: When a new command reloads a counter that is still running, the counter keeps the larger of its remaining count and the new value. A shorter gap never shortens a wait already in progress.
- R7: A gap of 0 or 1 allows a WRITE in the very next cycle. Counters stop at zero and never wrap, so an idle block keeps `wr_ok` at 1.
- R8: A command uses the register value held before the cycle's register write. A command in the same cycle as a register write uses the old value. Counts already running are not changed by a register write.
- R9: Command codes on `cmd_type` are 0 no-op, 1 ACT, 2 READ, 3 WRITE. A no-op changes no counter. A command never changes `wr_ok` within its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Spacing register write strobe |
| cfg_wdata | input | 16 | Spacing register write data |
| cfg_rdata | output | 16 | Spacing register contents |
| cmd_type | input | 2 | Issued command: 0 no-op, 1 ACT, 2 READ, 3 WRITE |
| cmd_rank | input | $clog2(NUM_RANKS) | Rank of the issued command |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank of the issued command |
| req_rank | input | $clog2(NUM_RANKS) | Rank of the proposed WRITE |
| req_bank | input | $clog2(NUM_BANKS) | Bank of the proposed WRITE |
| wr_ok | output | 1 | The proposed WRITE meets every spacing rule |

## Verification
Two events collide in the same cycle: a register write landing together with a command that loads a counter, and a new WRITE reloading a rank counter that an earlier WRITE left running. The bench provokes the first by driving `cfg_we` and an ACT on the same edge. It expects the old gap to govern that ACT and the new gap to govern the next one. It provokes the second with a long different-rank write followed at once by a short same-rank write, and expects the longer remaining wait to decide when `wr_ok` rises.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int FW = 4;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [FW-1:0] act_wr;
    logic [FW-1:0] wr_same;
    logic [FW-1:0] wr_diff;
    logic [FW-1:0] rd_wr;
  } spacing_t;

  // A gap of N clocks becomes a counter start of N-1: the counter reaches
  // zero in the cycle where the gap is met.
  function automatic logic [FW-1:0] gap_to_load(input logic [FW-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction
endpackage

// File: rtl/wsc_cfg_reg.sv
module wsc_cfg_reg
  import wsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output spacing_t    q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= spacing_t'(wdata);
  end

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == spacing_t'($past(wdata))));
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/wsc_timer.sv
module wsc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] dec;
  logic [W-1:0] nxt;

  always_comb begin
    dec = (cnt == '0) ? '0 : cnt - 1'b1;
    nxt = dec;
    if (load && (load_val > dec)) nxt = load_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  a_r6_keep_larger: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt >= $past(load_val)));
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wsc_cmd_dec.sv
module wsc_cmd_dec
  import wsc_pkg::*;
#(
  parameter int NR = 2,
  parameter int NB = 8,
  parameter int RW = 1,
  parameter int BW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [RW-1:0]    rank,
  input  logic [BW-1:0]    bank,
  output logic [NR*NB-1:0] act_hit,
  output logic [NR-1:0]    wr_own,
  output logic [NR-1:0]    wr_other,
  output logic             rd_hit
);
  assign rd_hit = (cmd == CMD_RD);

  for (genvar r = 0; r < NR; r++) begin : g_rank
    assign wr_own[r]   = (cmd == CMD_WR) && (rank == RW'(r));
    assign wr_other[r] = (cmd == CMD_WR) && (rank != RW'(r));
    for (genvar b = 0; b < NB; b++) begin : g_bank
      assign act_hit[r*NB+b] = (cmd == CMD_ACT) && (rank == RW'(r)) && (bank == BW'(b));
    end
  end

  a_r2_one_bank_per_act: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_hit));
  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) |-> (act_hit == '0 && wr_own == '0 && wr_other == '0 && !rd_hit));
endmodule

// File: rtl/wr_space_chk.sv
module wr_space_chk
  import wsc_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  localparam int RW  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic [1:0]    cmd_type,
  input  logic [RW-1:0] cmd_rank,
  input  logic [BW-1:0] cmd_bank,
  input  logic [RW-1:0] req_rank,
  input  logic [BW-1:0] req_bank,
  output logic          wr_ok
);
  localparam int NRB = NUM_RANKS * NUM_BANKS;

  spacing_t          cfg_q;
  cmd_e              cmd;
  logic [NRB-1:0]    act_hit;
  logic [NUM_RANKS-1:0] wr_own, wr_other;
  logic              rd_hit;

  logic [FW-1:0]     rb_cnt [NRB];
  logic [FW-1:0]     rk_cnt [NUM_RANKS];
  logic [FW-1:0]     rd_cnt;
  logic [NRB-1:0]    rb_zero;
  logic [NUM_RANKS-1:0] rk_zero;

  assign cmd       = cmd_e'(cmd_type);
  assign cfg_rdata = cfg_q;

  wsc_cfg_reg i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  wsc_cmd_dec #(.NR(NUM_RANKS), .NB(NUM_BANKS), .RW(RW), .BW(BW)) i_dec (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rank(cmd_rank), .bank(cmd_bank),
    .act_hit(act_hit), .wr_own(wr_own), .wr_other(wr_other), .rd_hit(rd_hit)
  );

  for (genvar i = 0; i < NRB; i++) begin : g_rb
    wsc_timer #(.W(FW)) i_tmr (
      .clk(clk), .rst_n(rst_n), .load(act_hit[i]),
      .load_val(gap_to_load(cfg_q.act_wr)), .cnt(rb_cnt[i])
    );
    assign rb_zero[i] = (rb_cnt[i] == '0);
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rk
    logic [FW-1:0] rk_load_val;
    assign rk_load_val = wr_own[r] ? gap_to_load(cfg_q.wr_same) : gap_to_load(cfg_q.wr_diff);
    wsc_timer #(.W(FW)) i_tmr (
      .clk(clk), .rst_n(rst_n), .load(wr_own[r] | wr_other[r]),
      .load_val(rk_load_val), .cnt(rk_cnt[r])
    );
    assign rk_zero[r] = (rk_cnt[r] == '0);
  end

  wsc_timer #(.W(FW)) i_rd_tmr (
    .clk(clk), .rst_n(rst_n), .load(rd_hit),
    .load_val(gap_to_load(cfg_q.rd_wr)), .cnt(rd_cnt)
  );

  logic rb_sel, rk_sel;
  always_comb begin
    rb_sel = 1'b0;
    rk_sel = 1'b0;
    for (int i = 0; i < NRB; i++)
      if ((int'(req_rank) * NUM_BANKS + int'(req_bank)) == i) rb_sel = rb_zero[i];
    for (int r = 0; r < NUM_RANKS; r++)
      if (int'(req_rank) == r) rk_sel = rk_zero[r];
  end

  assign wr_ok = rb_sel && rk_sel && (rd_cnt == '0);

  a_r5_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD && cfg_q.rd_wr > 4'd1) |=> !wr_ok);
  a_r3_same_rank_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR && cfg_q.wr_same > 4'd1) |=> (req_rank != $past(cmd_rank) || !wr_ok));
  a_r2_act_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && cfg_q.act_wr > 4'd1)
      |=> (req_rank != $past(cmd_rank) || req_bank != $past(cmd_bank) || !wr_ok));
endmodule

// File: tb/test_wr_space_chk.sv
`timescale 1ns/1ps
module test_wr_space_chk;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [1:0]  cmd_type;
  logic [0:0]  cmd_rank, req_rank;
  logic [2:0]  cmd_bank, req_bank;
  logic        wr_ok;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wr_space_chk i_wr_space_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_type(cmd_type), .cmd_rank(cmd_rank),
    .cmd_bank(cmd_bank), .req_rank(req_rank), .req_bank(req_bank), .wr_ok(wr_ok)
  );

  localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;

  function automatic logic [15:0] cfgv(int a, int s, int d, int r);
    return {4'(a), 4'(s), 4'(d), 4'(r)};
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wr_ok=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic probe(input int r, input int b, input logic exp, input string tag);
    req_rank = 1'(r); req_bank = 3'(b);
    #1;
    check(wr_ok, exp, tag);
  endtask

  task automatic set_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [1:0] t, input int r, input int b);
    cmd_type = t; cmd_rank = 1'(r); cmd_bank = 3'(b);
    @(negedge clk);
    cmd_type = NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    n_chk++;
    if (cfg_rdata !== 16'h0000) begin
      n_fail++; $display("FAIL R1: cfg_rdata=%h expected 0000", cfg_rdata);
    end
    probe(0, 0, 1'b1, "R7 idle after reset rank0");
    probe(1, 7, 1'b1, "R7 idle after reset rank1");
    set_cfg(16'hA5C3);
    n_chk++;
    if (cfg_rdata !== 16'hA5C3) begin
      n_fail++; $display("FAIL R1: cfg_rdata=%h expected a5c3", cfg_rdata);
    end
  endtask

  task automatic t_act;
    set_cfg(cfgv(5, 0, 0, 0));
    send(ACT, 0, 3);
    for (int k = 1; k <= 6; k++) begin
      probe(0, 3, k >= 5, "R2 activated bank");
      if (k == 1) begin
        probe(0, 4, 1'b1, "R2 other bank free");
        probe(1, 3, 1'b1, "R2 other rank free");
      end
      @(negedge clk);
    end
  endtask

  task automatic t_write_ranks;
    set_cfg(cfgv(0, 6, 2, 0));
    send(WR, 0, 1);
    for (int k = 1; k <= 7; k++) begin
      probe(0, 5, k >= 6, "R3 same rank");
      probe(1, 5, k >= 2, "R4 other rank");
      @(negedge clk);
    end
  endtask

  task automatic t_read;
    set_cfg(cfgv(0, 0, 0, 4));
    send(RD, 1, 2);
    for (int k = 1; k <= 5; k++) begin
      probe(0, 0, k >= 4, "R5 read blocks rank0");
      probe(1, 5, k >= 4, "R5 read blocks rank1");
      @(negedge clk);
    end
  endtask

  task automatic t_keep_larger;
    set_cfg(cfgv(0, 2, 9, 0));
    send(WR, 1, 0);
    send(WR, 0, 0);
    for (int k = 1; k <= 9; k++) begin
      probe(0, 0, k >= 8, "R6 longer wait kept");
      @(negedge clk);
    end
  endtask

  task automatic t_small_gaps;
    set_cfg(cfgv(1, 1, 0, 1));
    send(ACT, 1, 1);
    probe(1, 1, 1'b1, "R7 act gap 1");
    send(WR, 1, 1);
    probe(1, 1, 1'b1, "R7 same-rank gap 1");
    probe(0, 1, 1'b1, "R7 diff-rank gap 0");
    send(RD, 0, 0);
    probe(0, 6, 1'b1, "R7 read gap 1");
    idle(20);
    probe(1, 6, 1'b1, "R7 no wrap after idle");
  endtask

  task automatic t_cfg_timing;
    set_cfg(cfgv(3, 0, 0, 0));
    cfg_we = 1'b1; cfg_wdata = cfgv(7, 0, 0, 0);
    send(ACT, 1, 6);
    cfg_we = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      probe(1, 6, k >= 3, "R8 same-cycle write uses old gap");
      @(negedge clk);
    end
    send(ACT, 1, 6);
    for (int k = 1; k <= 8; k++) begin
      probe(1, 6, k >= 7, "R8 later act uses new gap");
      @(negedge clk);
    end
    set_cfg(cfgv(6, 0, 0, 0));
    send(ACT, 0, 1);
    probe(0, 1, 1'b0, "R8 running count k1");
    set_cfg(cfgv(1, 0, 0, 0));
    for (int k = 2; k <= 7; k++) begin
      probe(0, 1, k >= 6, "R8 running count unchanged");
      @(negedge clk);
    end
  endtask

  task automatic t_same_cycle;
    set_cfg(cfgv(5, 5, 5, 5));
    cmd_type = ACT; cmd_rank = 1'b0; cmd_bank = 3'd2;
    probe(0, 2, 1'b1, "R9 act not seen in own cycle");
    @(negedge clk);
    cmd_type = NOP;
    probe(0, 2, 1'b0, "R9 act seen next cycle");
    idle(6);
    cmd_type = NOP; cmd_rank = 1'b1; cmd_bank = 3'd4;
    @(negedge clk);
    probe(1, 4, 1'b1, "R9 nop leaves bank free");
    probe(0, 4, 1'b1, "R9 nop leaves rank free");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cmd_type = NOP; cmd_rank = '0; cmd_bank = '0;
    req_rank = '0; req_bank = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;        idle(12);
    t_act;          idle(12);
    t_write_ranks;  idle(12);
    t_read;         idle(12);
    t_keep_larger;  idle(12);
    t_small_gaps;   idle(12);
    t_cfg_timing;   idle(12);
    t_same_cycle;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule